// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a display pipeline, and it always runs as the timing master. A pixel counter runs along each line. A half-line counter runs down each field, moving two half-lines per line because the fields are progressive. Each field is marked top or bottom, and the two kinds alternate.

Four outputs are decoded from the count state in the same cycle, with no added latency:
- an active-video window flag;
- four independent horizontal sync lines;
- four independent vertical sync lines;
- a level interrupt.

The vertical syncs are set by a line and pixel position in the field, so each vertical edge can sit anywhere inside a line.

Software controls the block through a simple word-addressed register port. Reads return data one cycle after the request. Every write takes effect on the clock edge that captures it. The block has no streaming data path, so the register port has no valid/ready handshake: a request is accepted in any cycle where `bus_en` is high.

Top module: `video_timing_gen`

## Requirements
- R1: The pixel position counts from 0 up to line length minus 1 (register 0x04, low 16 bits) and then returns to 0, where the line number goes up by one. Lines are numbered from 1. A field ends after the line whose doubled number reaches the half-line count (register 0x08); the next field then starts at line 1, pixel 0.
- R2: After reset or restart the current field is top. The field kind flips at every field end, and each output uses the settings for the current field.
- R3: `active_o` is high when both of these hold for the current field's window: the line lies between the first and last line, inclusive, and the pixel lies between the first and last pixel, inclusive. The top window is at 0x10 (first) and 0x14 (last); the bottom window is at 0x18 and 0x1C. In each word the line is in bits 31:16 and the pixel in bits 15:0.
- R4: `hsync_o[k]` is high for pixels in the range from the start pixel up to, but not including, the stop pixel. Sync group k starts at 0x40+0x20*k; its word +0x00 holds the start pixel in bits 15:0 and the stop pixel in bits 31:16. When stop is less than start the range wraps past the line end. When they are equal the output never goes high.
- R5: `vsync_o[k]` is high from the rise point up to, but not including, the fall point, ordered by line and then pixel. The rise point is the line in bits 15:0 of the line word and the pixel in bits 15:0 of the offset word. The fall point uses bits 31:16 of the same two words. The top field uses the line word at +0x04 and the offset word at +0x0C; the bottom field uses +0x08 and +0x10. The range wraps across the field end, and equal points give no pulse.
- R6: At each field end, status bit 1 is set if the new field is top and status bit 0 is set if it is bottom. Status reads at 0x20. `irq_o` is the OR of status AND mask.
- R7: Writing ones to 0x24 clears those status bits. A set on the same edge wins over the clear. Writing ones to 0x28 sets mask bits and writing ones to 0x2C clears them.
- R8: Writing a word with bit 0 high to 0x0C moves the position to line 1, pixel 0, top field, on that edge. It leaves status unchanged.
- R9: The counters advance only while the mode register (0x00, bits 7:0) holds 0. Any other value freezes the position and every output.
- R10: All registers reset to 0. Reads return the value written, with these exceptions: status is read at 0x20, the mask is read at 0x28, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| active_o | output | 1 | Active-video window flag |
| hsync_o | output | 4 | Horizontal sync per output |
| vsync_o | output | 4 | Vertical sync per output |
| irq_o | output | 1 | Field interrupt |

## Verification
The hardest case to reach from the ports is a status clear that lands on the very edge where a field ends. In that case the new field's bit must survive while the other bit is cleared. The bench keeps its own position model and waits until that model sits one pixel before the last pixel of the last line. It then issues the clear so that the write is captured on the wrap edge, and reads status back. The bench also sweeps every pixel of several fields under two geometries. Those geometries include a one-pixel vertical pulse, a wrapped horizontal range, a pulse that crosses the field end, and an empty range.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int OFF_MODE     = 'h00;
  localparam int OFF_LINE_LEN = 'h04;
  localparam int OFF_HALF     = 'h08;
  localparam int OFF_RESTART  = 'h0C;
  localparam int OFF_WIN_TF   = 'h10;
  localparam int OFF_WIN_TL   = 'h14;
  localparam int OFF_WIN_BF   = 'h18;
  localparam int OFF_WIN_BL   = 'h1C;
  localparam int OFF_STAT     = 'h20;
  localparam int OFF_STAT_CLR = 'h24;
  localparam int OFF_MASK_SET = 'h28;
  localparam int OFF_MASK_CLR = 'h2C;
  localparam int SYNC_BASE    = 'h40;
  localparam int SYNC_STRIDE  = 'h20;

  typedef struct packed {
    logic [31:0] horiz;
    logic [31:0] line_top;
    logic [31:0] line_bot;
    logic [31:0] offs_top;
    logic [31:0] offs_bot;
  } sync_cfg_t;

  typedef struct packed {
    logic [31:0] top_first;
    logic [31:0] top_last;
    logic [31:0] bot_first;
    logic [31:0] bot_last;
  } win_cfg_t;

  // half-open range test that wraps when last < first
  function automatic logic span_hit(input logic [31:0] pos,
                                    input logic [31:0] first,
                                    input logic [31:0] last);
    if (first <= last) return (pos >= first) && (pos < last);
    else               return (pos >= first) || (pos < last);
  endfunction
endpackage

// File: rtl/vtg_counters.sv
module vtg_counters #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] line_len,
  input  logic [CW-1:0] half_lines,
  output logic [CW-1:0] px_o,
  output logic [CW-1:0] line_o,
  output logic          bottom_o,
  output logic          wrap_o
);
  localparam logic [CW:0] ONE = (CW+1)'(1);
  localparam logic [CW:0] TWO = (CW+1)'(2);

  logic [CW-1:0] px_q, hl_q;
  logic          bot_q;
  logic [CW:0]   px_next, hl_next;
  logic          px_end, hl_end;

  assign px_next = {1'b0, px_q} + ONE;
  assign hl_next = {1'b0, hl_q} + TWO;
  assign px_end  = px_next >= {1'b0, line_len};
  assign hl_end  = hl_next >= {1'b0, half_lines};
  assign wrap_o  = run && !restart && px_end && hl_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_q  <= '0;
      hl_q  <= '0;
      bot_q <= 1'b0;
    end else if (restart) begin
      px_q  <= '0;
      hl_q  <= '0;
      bot_q <= 1'b0;
    end else if (run) begin
      if (px_end) begin
        px_q <= '0;
        if (hl_end) begin
          hl_q  <= '0;
          bot_q <= !bot_q;
        end else begin
          hl_q <= hl_next[CW-1:0];
        end
      end else begin
        px_q <= px_next[CW-1:0];
      end
    end
  end

  assign px_o     = px_q;
  assign line_o   = (hl_q >> 1) + CW'(1);
  assign bottom_o = bot_q;

  assert_line_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && px_end && !hl_end) |=> (line_o == $past(line_o) + CW'(1)));
  assert_field_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (bottom_o != $past(bottom_o)));
  assert_restart_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (px_o == '0 && line_o == CW'(1) && !bottom_o));
  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> ($stable(px_o) && $stable(line_o) && $stable(bottom_o)));
endmodule

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int AW = 10,
  parameter int NS = 4,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          set_top,
  input  logic          set_bot,
  output logic          run_o,
  output logic          restart_o,
  output logic [CW-1:0] line_len_o,
  output logic [CW-1:0] half_lines_o,
  output win_cfg_t      win_o,
  output sync_cfg_t     sync_o [NS],
  output logic          irq_o
);
  localparam int SW = 2;

  logic            wr, rd;
  logic [7:0]      mode_q;
  logic [31:0]     len_q, half_q;
  win_cfg_t        win_q;
  sync_cfg_t       sync_q [NS];
  logic [SW-1:0]   stat_q, mask_q, stat_clr, stat_set;
  logic            wr_mclr;
  logic [31:0]     rd_mux;

  assign wr       = bus_en && bus_we;
  assign rd       = bus_en && !bus_we;
  assign wr_mclr  = wr && (bus_addr == AW'(OFF_MASK_CLR));
  assign stat_clr = (wr && bus_addr == AW'(OFF_STAT_CLR)) ? bus_wdata[SW-1:0] : '0;
  assign stat_set = {set_top, set_bot};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      len_q  <= '0;
      half_q <= '0;
      win_q  <= '0;
    end else if (wr) begin
      case (bus_addr)
        AW'(OFF_MODE):     mode_q          <= bus_wdata[7:0];
        AW'(OFF_LINE_LEN): len_q           <= bus_wdata;
        AW'(OFF_HALF):     half_q          <= bus_wdata;
        AW'(OFF_WIN_TF):   win_q.top_first <= bus_wdata;
        AW'(OFF_WIN_TL):   win_q.top_last  <= bus_wdata;
        AW'(OFF_WIN_BF):   win_q.bot_first <= bus_wdata;
        AW'(OFF_WIN_BL):   win_q.bot_last  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NS; k++) sync_q[k] <= '0;
    end else if (wr) begin
      for (int k = 0; k < NS; k++) begin
        if (bus_addr == AW'(SYNC_BASE + k*SYNC_STRIDE + 'h00)) sync_q[k].horiz    <= bus_wdata;
        if (bus_addr == AW'(SYNC_BASE + k*SYNC_STRIDE + 'h04)) sync_q[k].line_top <= bus_wdata;
        if (bus_addr == AW'(SYNC_BASE + k*SYNC_STRIDE + 'h08)) sync_q[k].line_bot <= bus_wdata;
        if (bus_addr == AW'(SYNC_BASE + k*SYNC_STRIDE + 'h0C)) sync_q[k].offs_top <= bus_wdata;
        if (bus_addr == AW'(SYNC_BASE + k*SYNC_STRIDE + 'h10)) sync_q[k].offs_bot <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      if (wr && bus_addr == AW'(OFF_MASK_SET)) mask_q <= mask_q | bus_wdata[SW-1:0];
      else if (wr_mclr)                        mask_q <= mask_q & ~bus_wdata[SW-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(OFF_MODE):     rd_mux = 32'(mode_q);
      AW'(OFF_LINE_LEN): rd_mux = len_q;
      AW'(OFF_HALF):     rd_mux = half_q;
      AW'(OFF_WIN_TF):   rd_mux = win_q.top_first;
      AW'(OFF_WIN_TL):   rd_mux = win_q.top_last;
      AW'(OFF_WIN_BF):   rd_mux = win_q.bot_first;
      AW'(OFF_WIN_BL):   rd_mux = win_q.bot_last;
      AW'(OFF_STAT):     rd_mux = 32'(stat_q);
      AW'(OFF_MASK_SET): rd_mux = 32'(mask_q);
      default: ;
    endcase
    for (int k = 0; k < NS; k++) begin
      if (bus_addr == AW'(SYNC_BASE + k*SYNC_STRIDE + 'h00)) rd_mux = sync_q[k].horiz;
      if (bus_addr == AW'(SYNC_BASE + k*SYNC_STRIDE + 'h04)) rd_mux = sync_q[k].line_top;
      if (bus_addr == AW'(SYNC_BASE + k*SYNC_STRIDE + 'h08)) rd_mux = sync_q[k].line_bot;
      if (bus_addr == AW'(SYNC_BASE + k*SYNC_STRIDE + 'h0C)) rd_mux = sync_q[k].offs_top;
      if (bus_addr == AW'(SYNC_BASE + k*SYNC_STRIDE + 'h10)) rd_mux = sync_q[k].offs_bot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  assign run_o        = (mode_q == 8'd0);
  assign restart_o    = wr && (bus_addr == AW'(OFF_RESTART)) && bus_wdata[0];
  assign line_len_o   = len_q[CW-1:0];
  assign half_lines_o = half_q[CW-1:0];
  assign win_o        = win_q;
  assign sync_o       = sync_q;
  assign irq_o        = |(stat_q & mask_q);

  assert_top_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_top |=> stat_q[1]);
  assert_bot_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_bot |=> stat_q[0]);
  assert_clear_bit0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr[0] && !set_bot) |=> !stat_q[0]);
  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mclr && bus_wdata[1]) |=> !mask_q[1]);
endmodule

// File: rtl/vtg_sync_unit.sv
module vtg_sync_unit
  import vtg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] line,
  input  logic          bottom,
  input  sync_cfg_t     cfg,
  output logic          hs,
  output logic          vs
);
  logic [31:0] vline, voffs, pos;

  assign vline = bottom ? cfg.line_bot : cfg.line_top;
  assign voffs = bottom ? cfg.offs_bot : cfg.offs_top;
  assign pos   = {16'(line), 16'(px)};

  assign hs = span_hit(32'(px), {16'd0, cfg.horiz[15:0]}, {16'd0, cfg.horiz[31:16]});
  assign vs = span_hit(pos, {vline[15:0], voffs[15:0]}, {vline[31:16], voffs[31:16]});
endmodule

// File: rtl/vtg_window.sv
module vtg_window
  import vtg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] line,
  input  logic          bottom,
  input  win_cfg_t      cfg,
  output logic          active
);
  logic [31:0] first, last;
  logic [15:0] ln, pc;

  assign first  = bottom ? cfg.bot_first : cfg.top_first;
  assign last   = bottom ? cfg.bot_last  : cfg.top_last;
  assign ln     = 16'(line);
  assign pc     = 16'(px);
  assign active = (ln >= first[31:16]) && (ln <= last[31:16]) &&
                  (pc >= first[15:0])  && (pc <= last[15:0]);
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int AW = 10,
  parameter int NS = 4,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          active_o,
  output logic [NS-1:0] hsync_o,
  output logic [NS-1:0] vsync_o,
  output logic          irq_o
);
  logic          run, restart, wrap, bottom;
  logic [CW-1:0] line_len, half_lines, px, line;
  win_cfg_t      win;
  sync_cfg_t     sync_cfg [NS];

  vtg_regs #(.AW(AW), .NS(NS), .CW(CW)) u_regs (
    .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .set_top(wrap && bottom), .set_bot(wrap && !bottom),
    .run_o(run), .restart_o(restart), .line_len_o(line_len),
    .half_lines_o(half_lines), .win_o(win), .sync_o(sync_cfg), .irq_o(irq_o)
  );

  vtg_counters #(.CW(CW)) u_cnt (
    .clk, .rst_n, .run, .restart, .line_len, .half_lines,
    .px_o(px), .line_o(line), .bottom_o(bottom), .wrap_o(wrap)
  );

  vtg_window #(.CW(CW)) u_win (
    .px, .line, .bottom, .cfg(win), .active(active_o)
  );

  for (genvar k = 0; k < NS; k++) begin : g_sync
    vtg_sync_unit #(.CW(CW)) u_sync (
      .px, .line, .bottom, .cfg(sync_cfg[k]), .hs(hsync_o[k]), .vs(vsync_o[k])
    );
  end
endmodule

// File: tb/sim_video_timing_gen.sv
module sim_video_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        active_o, irq_o;
  logic [3:0]  hsync_o, vsync_o;

  int n_chk = 0, n_fail = 0;
  logic chk_on = 1'b0;

  video_timing_gen u0 (.*);

  always #10 clk = ~clk;

  // reference model state
  int          m_px, m_line, m_len, m_half;
  logic        m_bot;
  logic [7:0]  m_mode;
  logic [1:0]  m_stat, m_mask, cap_stat;
  logic [31:0] m_win [4];
  logic [31:0] m_sync [4][5];

  always @(posedge clk) begin : mdl
    logic wr, wrap;
    logic [1:0] clr, set;
    if (!rst_n) begin
      m_px <= 0; m_line <= 1; m_bot <= 1'b0; m_len <= 0; m_half <= 0;
      m_mode <= '0; m_stat <= '0; m_mask <= '0;
      for (int i = 0; i < 4; i++) m_win[i] <= '0;
      for (int k = 0; k < 4; k++) for (int j = 0; j < 5; j++) m_sync[k][j] <= '0;
    end else begin
      wr = bus_en && bus_we;
      wrap = 1'b0;
      if (wr && bus_addr == 10'h0C && bus_wdata[0]) begin
        m_px <= 0; m_line <= 1; m_bot <= 1'b0;
      end else if (m_mode == 8'd0) begin
        if (m_px + 1 >= m_len) begin
          m_px <= 0;
          if (2*m_line >= m_half) begin
            m_line <= 1; m_bot <= !m_bot; wrap = 1'b1;
          end else m_line <= m_line + 1;
        end else m_px <= m_px + 1;
      end
      set = wrap ? (m_bot ? 2'b10 : 2'b01) : 2'b00;
      clr = (wr && bus_addr == 10'h24) ? bus_wdata[1:0] : 2'b00;
      m_stat <= (m_stat & ~clr) | set;
      if (wr) begin
        case (bus_addr)
          10'h00: m_mode <= bus_wdata[7:0];
          10'h04: m_len  <= int'(bus_wdata[15:0]);
          10'h08: m_half <= int'(bus_wdata[15:0]);
          10'h10: m_win[0] <= bus_wdata;
          10'h14: m_win[1] <= bus_wdata;
          10'h18: m_win[2] <= bus_wdata;
          10'h1C: m_win[3] <= bus_wdata;
          10'h28: m_mask <= m_mask | bus_wdata[1:0];
          10'h2C: m_mask <= m_mask & ~bus_wdata[1:0];
          default: ;
        endcase
        for (int k = 0; k < 4; k++)
          for (int j = 0; j < 5; j++)
            if (int'(bus_addr) == 'h40 + 'h20*k + 4*j) m_sync[k][j] <= bus_wdata;
      end
    end
  end

  function automatic logic in_span(input longint p, input longint a, input longint b);
    if (a <= b) return (p >= a) && (p < b);
    return (p >= a) || (p < b);
  endfunction

  function automatic logic exp_act();
    logic [31:0] f, l;
    f = m_bot ? m_win[2] : m_win[0];
    l = m_bot ? m_win[3] : m_win[1];
    return (m_line >= int'(f[31:16])) && (m_line <= int'(l[31:16])) &&
           (m_px >= int'(f[15:0])) && (m_px <= int'(l[15:0]));
  endfunction

  function automatic logic exp_hs(input int k);
    return in_span(m_px, m_sync[k][0][15:0], m_sync[k][0][31:16]);
  endfunction

  function automatic logic exp_vs(input int k);
    logic [31:0] vl, vo;
    vl = m_bot ? m_sync[k][2] : m_sync[k][1];
    vo = m_bot ? m_sync[k][4] : m_sync[k][3];
    return in_span(longint'(m_line)*65536 + m_px,
                   longint'(vl[15:0])*65536 + vo[15:0],
                   longint'(vl[31:16])*65536 + vo[31:16]);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (line %0d px %0d)", tag, act, exp, m_line, m_px);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk(active_o, exp_act(), "R3 window per line/field (R1 R2)");
      for (int k = 0; k < 4; k++) begin
        chk(hsync_o[k], exp_hs(k), "R4 hsync range (R1)");
        chk(vsync_o[k], exp_vs(k), "R5 vsync range per field (R2)");
      end
      chk(irq_o, |(m_stat & m_mask), "R6 irq");
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a[9:0]; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a[9:0]; cap_stat = m_stat;
    @(negedge clk);
    d = bus_rdata; bus_en = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, s0;
    logic bot_before;
    logic [8:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1'b1;
    @(negedge clk);
    chk(irq_o, 0, "R10 reset irq");
    chk(active_o, 0, "R10 reset window");
    rd('h04, d); chk(d, 0, "R10 reset line length");
    rd('h20, d); chk(d, 32'(cap_stat), "R10 status after reset (R6)");

    // geometry A: 16 pixels, 10 lines
    wr('h04, 16); wr('h08, 20);
    wr('h10, 32'h0003_0004); wr('h14, 32'h0008_000D);
    wr('h18, 32'h0002_0002); wr('h1C, 32'h0009_000F);
    wr('h40, 32'h0009_0005); wr('h44, 32'h0004_0001); wr('h48, 32'h0004_0001);
    wr('h4C, 32'h0005_0005); wr('h50, 32'h0005_0005);
    wr('h60, 32'h0002_000E); wr('h64, 32'h0002_000A); wr('h68, 32'h0003_0002);
    wr('h6C, 32'h0007_0007); wr('h70, 32'h0000_0003);
    wr('h80, 32'h000F_0000); wr('h84, 32'h0002_0001); wr('h88, 32'h000A_0009);
    wr('h8C, 32'h0000_000F); wr('h90, 32'h000F_0000);
    wr('hA0, 32'h0006_0006); wr('hA4, 32'h0001_0001); wr('hA8, 32'h0001_000A);
    wr('hAC, 32'h0000_0000); wr('hB0, 32'h0000_0000);
    wr('h28, 2); wr('h0C, 1); wr('h24, 3);
    repeat (3*160 + 10) @(negedge clk);
    rd('h20, d); chk(d, 32'(cap_stat), "R6 status after three fields");

    // clear landing on the field-end edge
    while (!(m_px == 14 && m_line == 10)) @(negedge clk);
    bot_before = m_bot;
    wr('h24, 3);
    rd('h20, d);
    chk(d, bot_before ? 32'h2 : 32'h1, "R7 set wins over clear");
    wr('h24, 3);
    rd('h20, d); chk(d, 0, "R7 clear by ones");

    rd('h28, d); chk(d, 2, "R10 mask readback");
    wr('h2C, 2);
    rd('h28, d); chk(d, 0, "R7 mask clear");
    wr('h28, 3);

    // freeze
    wr('h00, 1);
    rd('h00, d); chk(d, 1, "R10 mode readback");
    snap = {active_o, hsync_o, vsync_o};
    repeat (20) @(negedge clk);
    chk({active_o, hsync_o, vsync_o}, snap, "R9 outputs held");
    wr('h00, 0);
    repeat (40) @(negedge clk);

    // restart mid-field
    while (m_line != 3) @(negedge clk);
    rd('h20, s0);
    wr('h0C, 1);
    repeat (4) @(negedge clk);
    chk(hsync_o[0], 0, "R8 R1 hsync0 low at pixel 4");
    @(negedge clk);
    chk(hsync_o[0], 1, "R8 R1 hsync0 high at pixel 5");
    rd('h20, d); chk(d, s0, "R8 status untouched");

    // geometry B: 12 pixels, 7 lines
    wr('h04, 12); wr('h08, 14);
    wr('h10, 32'h0001_0000); wr('h14, 32'h0007_000B);
    wr('h60, 32'h000B_0003);
    wr('h0C, 1);
    repeat (2*84 + 5) @(negedge clk);
    rd('h20, d); chk(d, 32'(cap_stat), "R6 status geometry B");

    rd('h70, d); chk(d, 32'h0000_0003, "R10 sync1 bottom offset readback");
    rd('h14, d); chk(d, 32'h0007_000B, "R10 window readback");
    rd('h04, d); chk(d, 12, "R10 line length readback");
    rd('h3C, d); chk(d, 0, "R10 unmapped reads zero");
    chk_on = 1'b0;
    summary();
    $finish;
  end
endmodule